// File: doc/BRIEF.md
# Checksummed 16-bit SPI Slave Command Port

This block is the slave end of a four-wire SPI link running in mode 0 (clock idles low, data is sampled on the rising edge). The master sends 16-bit command words. Each word carries a 4-bit register address, an 8-bit data byte and a 4-bit checksum. The block brings the serial clock, chip select and data line into the system clock domain through flop synchronisers. It shifts in the word MSB first and checks the checksum when chip select is released. A good word becomes a single-cycle request to the register logic behind the block. A bad word becomes a single-cycle error strobe instead.

During every transfer the block also shifts out a 16-bit reply on MISO. The reply is made of 12 bits supplied by the internal logic, followed by their 4-bit checksum. The 12 bits are captured when chip select falls. The reply clocked out during a transfer therefore answers the previous command. Every reply carries a valid checksum, whether or not its data means anything.

Top module: `spi_frame_slave`

## Requirements
- R1: While reset is held and just after it is released, `req_valid`, `err_strobe` and `miso` are all 0.
- R2: Command words are received MSB first, one bit on each rising SCLK edge while CS_n is low. Bits [15:12] are the address, bits [11:4] the data byte and bits [3:0] the checksum.
- R3: The checksum covers the upper 12 bits of a word, taken as three nibbles starting with the most significant one. The accumulator starts at 0. For each nibble it is rotated right by one bit, the nibble is added, and the sum is kept to 4 bits.
- R4: A word of exactly 16 bits whose checksum field matches the computed value produces `req_valid` high for exactly one cycle, a few cycles after CS_n rises, with `req_addr` = bits [15:12] and `req_data` = bits [11:4]. No error strobe is raised for it.
- R5: A 16-bit word whose checksum field does not match produces `err_strobe` for exactly one cycle and no request.
- R6: A transfer with any bit count other than 16 (fewer, more, or none at all) produces `err_strobe` for one cycle and no request.
- R7: MISO carries `{rsp_data, checksum(rsp_data)}` MSB first. Bit 15 is valid before the first rising SCLK edge, and each later bit appears after a falling SCLK edge. MISO holds steady between those events.
- R8: `rsp_data` is sampled when CS_n falls. Changes to it while CS_n is low have no effect on the bits shifted out in that transfer.
- R9: While CS_n is high (once its rise has been seen), MISO is driven 0.
- R10: `req_valid` and `err_strobe` are never high together. Each transfer produces exactly one of the two, and only as a result of CS_n rising.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the SCLK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock from the master |
| cs_n | input | 1 | Active-low chip select from the master |
| mosi | input | 1 | Serial command data from the master |
| miso | output | 1 | Serial reply data to the master |
| rsp_data | input | 12 | Reply payload from internal logic, captured when CS_n falls |
| req_valid | output | 1 | One-cycle strobe for a valid command word |
| req_addr | output | 4 | Address of the last valid command word |
| req_data | output | 8 | Data byte of the last valid command word |
| err_strobe | output | 1 | One-cycle strobe for a rejected transfer |

## Verification
The assertions assume the master keeps to mode 0 at a quarter of the system clock rate or slower. They also assume CS_n changes only while SCLK is low, and that a gap of several system cycles separates the CS_n edges from the SCLK edges. Under these conditions each synchronised edge is seen once and in order. The stimulus drives every SPI line on the falling system clock edge. It uses a half-period of five system cycles and leaves six idle cycles after CS_n falls and before CS_n rises. `rsp_data` is only changed while CS_n is high, except in the test that changes it deliberately in the middle of a transfer.

// File: rtl/spi_frm_pkg.sv
package spi_frm_pkg;
  localparam int FRAME_W = 16;
  localparam int CK_W    = 4;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 8;
  localparam int BODY_W  = FRAME_W - CK_W;
  localparam int RSP_W   = BODY_W;
  localparam int NIB_N   = BODY_W / CK_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [CK_W-1:0]   ck;
  } cmd_word_t;

  // rotate-right-and-add checksum, most significant nibble first
  function automatic logic [CK_W-1:0] bsd_ck(input logic [BODY_W-1:0] body);
    logic [CK_W-1:0] acc;
    acc = '0;
    for (int i = NIB_N - 1; i >= 0; i--) begin
      acc = {acc[0], acc[CK_W-1:1]} + body[i*CK_W +: CK_W];
    end
    return acc;
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W              = 3,
  parameter int STAGES         = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/spi_edge.sv
module spi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic cs_n_s,
  output logic cs_act,
  output logic cs_start,
  output logic cs_end,
  output logic sclk_rise,
  output logic sclk_fall
);
  logic sclk_q, cs_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_n_q <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      cs_n_q <= cs_n_s;
    end
  end

  assign cs_act    = ~cs_n_s;
  assign cs_start  = ~cs_n_s & cs_n_q;
  assign cs_end    = cs_n_s & ~cs_n_q;
  assign sclk_rise = cs_act & sclk_s & ~sclk_q;
  assign sclk_fall = cs_act & ~sclk_s & sclk_q;
endmodule

// File: rtl/spi_rx.sv
module spi_rx
  import spi_frm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_start,
  input  logic               sclk_rise,
  input  logic               mosi_s,
  output logic [FRAME_W-1:0] rx_word,
  output logic [CNT_W-1:0]   rx_cnt
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);

  logic [FRAME_W-1:0] word_n;
  logic [CNT_W-1:0]   cnt_n;
  logic               en;

  always_comb begin
    en     = cs_start | sclk_rise;
    word_n = rx_word;
    cnt_n  = rx_cnt;
    if (cs_start) begin
      word_n = '0;
      cnt_n  = '0;
    end else if (sclk_rise) begin
      word_n = {rx_word[FRAME_W-2:0], mosi_s};
      if (rx_cnt != CNT_SAT) cnt_n = rx_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_word <= '0;
      rx_cnt  <= '0;
    end else if (en) begin
      rx_word <= word_n;
      rx_cnt  <= cnt_n;
    end
  end
endmodule

// File: rtl/spi_tx.sv
module spi_tx
  import spi_frm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_start,
  input  logic             cs_end,
  input  logic             sclk_fall,
  input  logic [RSP_W-1:0] rsp_data,
  output logic             miso
);
  logic [FRAME_W-1:0] tx_q, tx_n;
  logic               en;

  always_comb begin
    en   = cs_start | cs_end | sclk_fall;
    tx_n = tx_q;
    if (cs_start)       tx_n = {rsp_data, bsd_ck(rsp_data)};
    else if (cs_end)    tx_n = '0;
    else if (sclk_fall) tx_n = {tx_q[FRAME_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  tx_q <= '0;
    else if (en) tx_q <= tx_n;
  end

  assign miso = tx_q[FRAME_W-1];
endmodule

// File: rtl/spi_frame_slave.sv
module spi_frame_slave
  import spi_frm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  input  logic [RSP_W-1:0]  rsp_data,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic              err_strobe
);
  logic [2:0]         pins_s;
  logic               cs_act, cs_start, cs_end, sclk_rise, sclk_fall;
  logic [FRAME_W-1:0] rx_word;
  logic [CNT_W-1:0]   rx_cnt;
  cmd_word_t          cmd;
  logic               frame_ok;
  logic               req_n, err_n;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({sclk, cs_n, mosi}), .dout(pins_s)
  );

  spi_edge u_edge (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pins_s[2]), .cs_n_s(pins_s[1]),
    .cs_act(cs_act), .cs_start(cs_start), .cs_end(cs_end),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
  );

  spi_rx u_rx (
    .clk(clk), .rst_n(rst_n),
    .cs_start(cs_start), .sclk_rise(sclk_rise), .mosi_s(pins_s[0]),
    .rx_word(rx_word), .rx_cnt(rx_cnt)
  );

  spi_tx u_tx (
    .clk(clk), .rst_n(rst_n),
    .cs_start(cs_start), .cs_end(cs_end), .sclk_fall(sclk_fall),
    .rsp_data(rsp_data), .miso(miso)
  );

  assign cmd      = cmd_word_t'(rx_word);
  assign frame_ok = (rx_cnt == CNT_W'(FRAME_W)) &&
                    (bsd_ck(rx_word[FRAME_W-1:CK_W]) == cmd.ck);

  always_comb begin
    req_n = cs_end & frame_ok;
    err_n = cs_end & ~frame_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid  <= 1'b0;
      err_strobe <= 1'b0;
    end else begin
      req_valid  <= req_n;
      err_strobe <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_addr <= '0;
      req_data <= '0;
    end else if (req_n) begin
      req_addr <= cmd.addr;
      req_data <= cmd.data;
    end
  end
endmodule

// File: rtl/spi_frame_slave_chk.sv
module spi_frame_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_act,
  input logic cs_start,
  input logic cs_end,
  input logic sclk_fall,
  input logic miso,
  input logic req_valid,
  input logic err_strobe
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && err_strobe)); // R10

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid); // R4

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_strobe |=> !err_strobe); // R5

  AST_STROBE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid || err_strobe) |-> $past(cs_end)); // R10

  AST_IDLE_MISO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && !cs_end) |-> !miso); // R9

  AST_MISO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && $past(cs_act) && !$past(sclk_fall) && !$past(cs_start))
      |-> $stable(miso)); // R7
endmodule

bind spi_frame_slave spi_frame_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_start(cs_start),
  .cs_end(cs_end), .sclk_fall(sclk_fall), .miso(miso),
  .req_valid(req_valid), .err_strobe(err_strobe)
);

// File: tb/sim_spi_frame_slave.sv
module sim_spi_frame_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 5;

  typedef struct packed {
    logic       is_req;
    logic [3:0] a;
    logic [7:0] d;
  } ev_t;

  logic clk = 1'b0;
  logic rst_n, sclk, cs_n, mosi, miso, req_valid, err_strobe;
  logic [11:0] rsp_data;
  logic [3:0]  req_addr;
  logic [7:0]  req_data;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;
  ev_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_frame_slave u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .rsp_data(rsp_data), .req_valid(req_valid),
    .req_addr(req_addr), .req_data(req_data), .err_strobe(err_strobe)
  );

  function automatic logic [3:0] ref_ck(input logic [11:0] w);
    int a = 0;
    for (int k = 2; k >= 0; k--) begin
      a = ((a >> 1) | ((a & 1) << 3));
      a = (a + ((w >> (4*k)) & 15)) & 15;
    end
    return a[3:0];
  endfunction

  function automatic logic [15:0] mk(input logic [3:0] a, input logic [7:0] d);
    return {a, d, ref_ck({a, d})};
  endfunction

  // reference event model, compared every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (req_valid && err_strobe) begin
        errors++;
        $display("FAIL R10 both strobes high: req=%0b err=%0b expected one", req_valid, err_strobe);
      end
      if (req_valid || err_strobe) begin
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R10 unexpected strobe req=%0b err=%0b expected none", req_valid, err_strobe);
        end else begin
          ev_t e;
          e = q.pop_front();
          if (e.is_req) begin
            if (!req_valid || req_addr != e.a || req_data != e.d) begin
              errors++;
              $display("FAIL R4 req=%0b addr=%h data=%h expected req=1 addr=%h data=%h",
                       req_valid, req_addr, req_data, e.a, e.d);
            end
          end else if (!err_strobe) begin
            errors++;
            $display("FAIL R5/R6 err=%0b req=%0b expected err=1", err_strobe, req_valid);
          end
        end
      end
    end
  end

  task automatic xfer(input logic [15:0] word, input int nbits,
                      input logic [11:0] rsp, input logic [11:0] rsp_mid,
                      input string tag);
    logic [15:0] got, exp_miso;
    bit good;
    got = '0;
    @(negedge clk) rsp_data = rsp;
    repeat (3) @(negedge clk);
    cs_n = 1'b0;
    exp_miso = {rsp, ref_ck(rsp)};
    repeat (6) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? word[15-i] : 1'b1;
      if (i == 8) rsp_data = rsp_mid;
      repeat (HALF_SCK) @(negedge clk);
      if (i < 16) got[15-i] = miso;
      sclk = 1'b1;
      repeat (HALF_SCK) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (6) @(negedge clk);
    good = (nbits == 16) && (ref_ck(word[15:4]) == word[3:0]);
    q.push_back('{is_req: good, a: word[15:12], d: word[11:4]});
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL %s missing strobe: pending=%0d expected 0", tag, q.size());
      q.delete();
    end
    if (nbits >= 16) begin
      checks++;
      if (got !== exp_miso) begin
        errors++;
        $display("FAIL R7/R8 miso word %h expected %h (%s)", got, exp_miso, tag);
      end
    end
    checks++;
    if (miso !== 1'b0) begin
      errors++;
      $display("FAIL R9 idle miso=%0b expected 0", miso);
    end
  endtask

  initial begin
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0; rsp_data = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (req_valid !== 1'b0 || err_strobe !== 1'b0 || miso !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset req=%0b err=%0b miso=%0b expected 0 0 0", req_valid, err_strobe, miso);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (req_valid !== 1'b0 || err_strobe !== 1'b0 || miso !== 1'b0) begin
      errors++;
      $display("FAIL R1 after reset req=%0b err=%0b miso=%0b expected 0 0 0", req_valid, err_strobe, miso);
    end
    // R2 R3 R4 valid words, several patterns
    xfer(mk(4'h3, 8'hA5), 16, 12'h5C3, 12'h5C3, "R4");
    xfer(mk(4'hF, 8'h00), 16, 12'hFFF, 12'hFFF, "R4");
    xfer(mk(4'h0, 8'hFF), 16, 12'h000, 12'h000, "R3");
    xfer(mk(4'h9, 8'h6E), 16, 12'h81E, 12'h81E, "R2");
    // R5 corrupted checksum
    xfer(mk(4'h3, 8'hA5) ^ 16'h0001, 16, 12'h123, 12'h123, "R5");
    xfer(mk(4'hC, 8'h3B) ^ 16'h0100, 16, 12'hABC, 12'hABC, "R5");
    // R6 wrong bit counts
    xfer(mk(4'h7, 8'h42), 10, 12'h777, 12'h777, "R6");
    xfer(mk(4'h7, 8'h42), 18, 12'h321, 12'h321, "R6");
    xfer(16'h0000, 0, 12'h000, 12'h000, "R6");
    // R8 reply payload changed mid-transfer must not alter MISO
    xfer(mk(4'h5, 8'h81), 16, 12'hA5A, 12'h0F0, "R8");
    // R7 one more reply pattern after the change
    xfer(mk(4'h1, 8'h10), 16, 12'h3C7, 12'h3C7, "R7");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired: done=0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule